// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a chain of transmit buffer descriptors that software has placed in a word-addressed descriptor memory. Each descriptor takes two 32-bit words. The word at the descriptor address carries a 16-bit flag field in bits 31:16 and a 16-bit byte count in bits 15:0. The word at the address plus 4 holds the buffer pointer. Software fills descriptors, sets each one's ready flag, and pulses `kick`. While `enable` is high, the walker reads descriptors one after another. For every ready descriptor it issues a one-cycle fetch request that carries the pointer and the byte count, which a payload mover downstream consumes. It then writes the descriptor back with the ready flag cleared.

Frames may be split across several buffers. The walker adds up the bytes of the current frame and holds every frame to a hard ceiling of `MAX_FRAME` bytes (2032 by default). When a buffer would cross the ceiling, its fetch length is cut to the room that is left and an oversize pulse is raised. The chain is closed by a per-descriptor wrap flag that sends the walker back to the programmed ring start. There is no fixed ring length.

Top module: `tbd_ring_walker`

## Requirements
- R1: After synchronous reset the walker is idle (`busy` low), `cur_ptr` and `ring` start are 0, and `fetch_valid`, `buf_done`, `frame_done` and `oversize` are low.
- R2: A `kick` sampled while `enable` is low starts nothing. No descriptor is read, no event is raised and the descriptor memory is left as it was.
- R3: For each processed descriptor at byte address A, the fetch request carries the word at A+4 as `fetch_ptr` and bits 15:0 of the word at A as the requested length.
- R4: A pass stops at the first descriptor whose ready flag (flag bit 15, word bit 31) is clear. `cur_ptr` is then left pointing at that descriptor.
- R5: A processed descriptor is written back to its own first word. The ready flag is cleared, and all other flag bits and the length field keep their values.
- R6: After a descriptor with the wrap flag (flag bit 13, word bit 29), the next address is the ring start. Otherwise the next address is the current one plus 8.
- R7: Writing the ring start forces its two low bits to zero and loads the same value into `cur_ptr`.
- R8: A buffer whose length would take the frame past `MAX_FRAME` bytes is cut to the remaining room, which can be 0, and raises `oversize`. A buffer that exactly reaches `MAX_FRAME` is not cut.
- R9: Every processed buffer raises `buf_done`. A buffer with the last flag (flag bit 11, word bit 27) also raises `frame_done`, reports the frame's total effective length on `frame_bytes`, and restarts the length count at zero.
- R10: A `kick` (with `enable` high) seen while a pass is running is remembered. It causes exactly one more pass once the current one stops, however many such kicks arrive.
- R11: `fetch_valid`, `buf_done`, `frame_done` and `oversize` are single-cycle pulses that rise together for the same buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Global run enable; kicks are honoured only while high |
| kick | input | 1 | Start a pass over the ring |
| ring_we | input | 1 | Write strobe for the ring start address |
| ring_wdata | input | 32 | Ring start byte address (low two bits dropped) |
| busy | output | 1 | A pass is in progress |
| cur_ptr | output | 32 | Byte address of the next descriptor to examine |
| desc_re | output | 1 | Descriptor memory read strobe (data returns next cycle) |
| desc_we | output | 1 | Descriptor memory write strobe |
| desc_addr | output | DESC_AW | Descriptor memory word address |
| desc_wdata | output | 32 | Descriptor write-back data |
| desc_rdata | input | 32 | Descriptor memory read data |
| fetch_valid | output | 1 | Buffer fetch request pulse |
| fetch_ptr | output | 32 | Buffer pointer of the request |
| fetch_len | output | 16 | Effective (possibly shortened) byte count |
| buf_done | output | 1 | Buffer processed pulse |
| frame_done | output | 1 | Last buffer of a frame processed pulse |
| oversize | output | 1 | Buffer was shortened by the frame ceiling |
| frame_bytes | output | 16 | Total frame length, valid with `frame_done` |

## Verification
The hardest states to reach are the length clamp and the remembered kick. For the clamp, a frame must first build up to exactly the ceiling, and then a later buffer must find zero room left. For the kick, it must land while a pass is already under way. The vector table builds one ring that covers both clamp cases: a two-buffer frame that lands on exactly 2032 bytes, then a single oversize buffer followed by a last buffer that gets zero bytes. The ring closes with a wrap back onto an already consumed descriptor. The remembered kick is reached by holding `kick` for two and three cycles over a ring with nothing ready. The pass length visible on `busy` must then double exactly once.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int WORD_W     = 32;
  localparam int FLAG_W     = 16;
  localparam int LEN_W      = 16;
  localparam int DESC_BYTES = 8;
  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD0  = 2'd1,
    ST_RD1  = 2'd2,
    ST_EVAL = 2'd3
  } walk_st_e;
endpackage

// File: rtl/tbd_len_clamp.sv
// Caps a buffer so the running frame length never exceeds MAX_FRAME.
module tbd_len_clamp #(
  parameter int MAX_FRAME = 2032,
  parameter int LEN_W     = 16,
  parameter int ACC_W     = 11
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [LEN_W-1:0] len,
  output logic [LEN_W-1:0] eff_len,
  output logic [ACC_W-1:0] acc_sum,
  output logic             over
);
  localparam int SUM_W = ((LEN_W > ACC_W) ? LEN_W : ACC_W) + 1;

  logic [SUM_W-1:0] sum;
  logic [ACC_W-1:0] room;

  always_comb begin
    sum     = SUM_W'(acc) + SUM_W'(len);
    room    = ACC_W'(MAX_FRAME) - acc;
    over    = (sum > SUM_W'(MAX_FRAME));
    eff_len = over ? LEN_W'(room) : len;
    acc_sum = over ? ACC_W'(MAX_FRAME) : ACC_W'(sum);
  end
endmodule

// File: rtl/tbd_next_addr.sv
// Chooses the following descriptor address: ring start on wrap, else a fixed step.
module tbd_next_addr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              wrap,
  output logic [ADDR_W-1:0] nxt
);
  assign nxt = wrap ? ring_base : (cur + ADDR_W'(STEP));
endmodule

// File: rtl/tbd_ring_walker.sv
module tbd_ring_walker
  import tbd_pkg::*;
#(
  parameter int DESC_AW   = 8,
  parameter int MAX_FRAME = 2032
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               kick,
  input  logic               ring_we,
  input  logic [WORD_W-1:0]  ring_wdata,
  output logic               busy,
  output logic [WORD_W-1:0]  cur_ptr,
  output logic               desc_re,
  output logic               desc_we,
  output logic [DESC_AW-1:0] desc_addr,
  output logic [WORD_W-1:0]  desc_wdata,
  input  logic [WORD_W-1:0]  desc_rdata,
  output logic               fetch_valid,
  output logic [WORD_W-1:0]  fetch_ptr,
  output logic [LEN_W-1:0]   fetch_len,
  output logic               buf_done,
  output logic               frame_done,
  output logic               oversize,
  output logic [LEN_W-1:0]   frame_bytes
);
  localparam int ACC_W = $clog2(MAX_FRAME + 1);
  localparam logic [WORD_W-1:0] ALIGN_MASK = ~WORD_W'(3);

  walk_st_e          st_q;
  logic [WORD_W-1:0] cur_q, base_q, nxt_ptr;
  logic [ACC_W-1:0]  acc_q, acc_sum;
  logic [FLAG_W-1:0] flags_q;
  logic [LEN_W-1:0]  len_q, eff_len;
  logic              over, pend_q;
  logic              is_ready, is_wrap, is_last, go_kick;
  logic [DESC_AW-1:0] w0_idx;

  assign is_ready = flags_q[FLAG_READY];
  assign is_wrap  = flags_q[FLAG_WRAP];
  assign is_last  = flags_q[FLAG_LAST];
  assign go_kick  = kick & enable;

  tbd_len_clamp #(.MAX_FRAME(MAX_FRAME), .LEN_W(LEN_W), .ACC_W(ACC_W)) u_clamp (
    .acc     (acc_q),
    .len     (len_q),
    .eff_len (eff_len),
    .acc_sum (acc_sum),
    .over    (over)
  );

  tbd_next_addr #(.ADDR_W(WORD_W), .STEP(DESC_BYTES)) u_next (
    .cur       (cur_q),
    .ring_base (base_q),
    .wrap      (is_wrap),
    .nxt       (nxt_ptr)
  );

  // Memory port decoded from registered state only.
  assign w0_idx     = cur_q[DESC_AW+1:2];
  assign desc_re    = (st_q == ST_RD0) || (st_q == ST_RD1);
  assign desc_addr  = w0_idx + DESC_AW'(st_q == ST_RD1);
  assign desc_we    = (st_q == ST_EVAL) && is_ready;
  assign desc_wdata = {flags_q & ~(FLAG_W'(1) << FLAG_READY), len_q};
  assign busy       = (st_q != ST_IDLE);
  assign cur_ptr    = cur_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      cur_q       <= '0;
      base_q      <= '0;
      acc_q       <= '0;
      flags_q     <= '0;
      len_q       <= '0;
      pend_q      <= 1'b0;
      fetch_valid <= 1'b0;
      fetch_ptr   <= '0;
      fetch_len   <= '0;
      buf_done    <= 1'b0;
      frame_done  <= 1'b0;
      oversize    <= 1'b0;
      frame_bytes <= '0;
    end else begin
      fetch_valid <= 1'b0;
      buf_done    <= 1'b0;
      frame_done  <= 1'b0;
      oversize    <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (go_kick) st_q <= ST_RD0;
        end
        ST_RD0: begin
          if (!enable) begin
            st_q   <= ST_IDLE;
            pend_q <= 1'b0;
          end else begin
            st_q <= ST_RD1;
            if (kick) pend_q <= 1'b1;
          end
        end
        ST_RD1: begin
          flags_q <= desc_rdata[WORD_W-1:LEN_W];
          len_q   <= desc_rdata[LEN_W-1:0];
          st_q    <= ST_EVAL;
          if (go_kick) pend_q <= 1'b1;
        end
        ST_EVAL: begin
          if (is_ready) begin
            fetch_valid <= 1'b1;
            fetch_ptr   <= desc_rdata;
            fetch_len   <= eff_len;
            buf_done    <= 1'b1;
            oversize    <= over;
            frame_done  <= is_last;
            frame_bytes <= is_last ? LEN_W'(acc_sum) : '0;
            acc_q       <= is_last ? '0 : acc_sum;
            cur_q       <= nxt_ptr;
            st_q        <= ST_RD0;
            if (go_kick) pend_q <= 1'b1;
          end else if (pend_q || go_kick) begin
            pend_q <= 1'b0;
            st_q   <= ST_RD0;
          end else begin
            st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
      if (ring_we) begin
        base_q <= ring_wdata & ALIGN_MASK;
        cur_q  <= ring_wdata & ALIGN_MASK;
      end
    end
  end
endmodule

// File: rtl/tbd_ring_walker_chk.sv
module tbd_ring_walker_chk #(
  parameter int MAX_FRAME = 2032
) (
  input logic        clk,
  input logic        rst,
  input logic        enable,
  input logic        kick,
  input logic        busy,
  input logic        ring_we,
  input logic [31:0] cur_ptr,
  input logic        desc_we,
  input logic [31:0] desc_wdata,
  input logic        fetch_valid,
  input logic [15:0] fetch_len,
  input logic        buf_done,
  input logic        frame_done,
  input logic        oversize
);
  AST_KICK_GATED: assert property (@(posedge clk) disable iff (rst)
    (!busy && kick && !enable) |=> !busy); // R2
  AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(ring_we)) |-> $stable(cur_ptr)); // R4
  AST_WB_READY_CLEAR: assert property (@(posedge clk) disable iff (rst)
    desc_we |-> !desc_wdata[31]); // R5
  AST_LEN_CAPPED: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |-> (fetch_len <= 16'(MAX_FRAME))); // R8
  AST_OVS_WITH_BUF: assert property (@(posedge clk) disable iff (rst)
    oversize |-> (buf_done && fetch_valid)); // R8
  AST_FRAME_WITH_BUF: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> (buf_done && fetch_valid)); // R9
  AST_BUF_PULSE: assert property (@(posedge clk) disable iff (rst)
    buf_done |=> !buf_done); // R11
endmodule

bind tbd_ring_walker tbd_ring_walker_chk #(.MAX_FRAME(MAX_FRAME)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .enable      (enable),
  .kick        (kick),
  .busy        (busy),
  .ring_we     (ring_we),
  .cur_ptr     (cur_ptr),
  .desc_we     (desc_we),
  .desc_wdata  (desc_wdata),
  .fetch_valid (fetch_valid),
  .fetch_len   (fetch_len),
  .buf_done    (buf_done),
  .frame_done  (frame_done),
  .oversize    (oversize)
);

// File: tb/sim_tbd_ring_walker.sv
`timescale 1ns/1ps
module sim_tbd_ring_walker;
  localparam int AW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst, enable, kick, ring_we;
  logic [31:0] ring_wdata, cur_ptr, desc_wdata, fetch_ptr;
  logic [31:0] desc_rdata = '0;
  logic busy, desc_re, desc_we, fetch_valid, buf_done, frame_done, oversize;
  logic [AW-1:0] desc_addr;
  logic [15:0] fetch_len, frame_bytes;

  tbd_ring_walker #(.DESC_AW(AW), .MAX_FRAME(2032)) u0 (
    .clk(clk), .rst(rst), .enable(enable), .kick(kick),
    .ring_we(ring_we), .ring_wdata(ring_wdata),
    .busy(busy), .cur_ptr(cur_ptr),
    .desc_re(desc_re), .desc_we(desc_we), .desc_addr(desc_addr),
    .desc_wdata(desc_wdata), .desc_rdata(desc_rdata),
    .fetch_valid(fetch_valid), .fetch_ptr(fetch_ptr), .fetch_len(fetch_len),
    .buf_done(buf_done), .frame_done(frame_done), .oversize(oversize),
    .frame_bytes(frame_bytes)
  );

  // Descriptor memory model, one-cycle read latency.
  logic [31:0] mem [256] = '{default: 32'h0};
  logic tb_we = 1'b0;
  logic [AW-1:0] tb_wa = '0;
  logic [31:0] tb_wd = '0;
  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (desc_we) mem[desc_addr] <= desc_wdata;
    if (desc_re) desc_rdata <= mem[desc_addr];
  end

  // Event log sampled away from the clock edge.
  int n_fetch = 0, n_evt = 0;
  logic [15:0] lg_len [16];
  logic [31:0] lg_ptr [16];
  logic [15:0] lg_fb  [16];
  logic        lg_ov  [16];
  logic        lg_fd  [16];
  always @(negedge clk) begin
    if (fetch_valid || buf_done || frame_done || oversize) n_evt++;
    if (fetch_valid && n_fetch < 16) begin
      lg_len[n_fetch] = fetch_len;
      lg_ptr[n_fetch] = fetch_ptr;
      lg_fb[n_fetch]  = frame_bytes;
      lg_ov[n_fetch]  = oversize;
      lg_fd[n_fetch]  = frame_done && buf_done;
      n_fetch++;
    end
  end

  int total = 0, fails = 0;
  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] w0(input bit r, input bit w, input bit l, input logic [15:0] len);
    return {r, 1'b0, w, 1'b0, l, 11'd0, len};
  endfunction

  task automatic mem_put(input logic [31:0] byte_addr, input logic [31:0] data);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = byte_addr[AW+1:2]; tb_wd = data;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic set_ring(input logic [31:0] v);
    @(negedge clk);
    ring_we = 1'b1; ring_wdata = v;
    @(negedge clk);
    ring_we = 1'b0;
  endtask

  // Holds kick for 'hold' cycles, returns the number of busy cycles seen.
  task automatic run_pass(input int hold, output int cyc);
    @(negedge clk);
    kick = 1'b1;
    cyc = 0;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      if (busy) cyc++;
    end
    kick = 1'b0;
    while (busy && cyc < 2000) begin
      @(negedge clk);
      if (busy) cyc++;
    end
  endtask

  // {ready, wrap, last, len, ptr, exp_len, exp_ovs, exp_frame_bytes}
  localparam logic [83:0] VEC [7] = '{
    {1'b1, 1'b0, 1'b0, 16'd100,  32'h1000_0000, 16'd100,  1'b0, 16'd0},
    {1'b1, 1'b0, 1'b1, 16'd60,   32'h1000_0100, 16'd60,   1'b0, 16'd160},
    {1'b1, 1'b0, 1'b0, 16'd1500, 32'h1000_0200, 16'd1500, 1'b0, 16'd0},
    {1'b1, 1'b0, 1'b1, 16'd532,  32'h1000_0300, 16'd532,  1'b0, 16'd2032},
    {1'b1, 1'b0, 1'b0, 16'd3000, 32'h1000_0400, 16'd2032, 1'b1, 16'd0},
    {1'b1, 1'b0, 1'b1, 16'd5,    32'h1000_0500, 16'd0,    1'b1, 16'd2032},
    {1'b1, 1'b1, 1'b1, 16'd10,   32'h1000_0600, 16'd10,   1'b0, 16'd10}
  };

  task automatic finish_up();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end

  initial begin
    int cyc, mark, evt0;
    rst = 1'b1; enable = 1'b0; kick = 1'b0; ring_we = 1'b0; ring_wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 cur_ptr", cur_ptr, 0);
    chk("R1 events", {fetch_valid, buf_done, frame_done, oversize}, 0);

    // Build the ring at 0x40.
    set_ring(32'h40);
    chk("R7 cur_ptr load", cur_ptr, 32'h40);
    for (int i = 0; i < 7; i++) begin
      mem_put(32'h40 + 8 * i, w0(VEC[i][83], VEC[i][82], VEC[i][81], VEC[i][80:65]));
      mem_put(32'h44 + 8 * i, VEC[i][64:33]);
    end

    // Kick with enable low.
    evt0 = n_evt;
    run_pass(1, cyc);
    repeat (4) @(negedge clk);
    chk("R2 no pass", cyc, 0);
    chk("R2 no events", n_evt - evt0, 0);
    chk("R2 desc untouched", mem[8'h10], w0(1, 0, 0, 16'd100));

    // Table-driven pass.
    enable = 1'b1;
    mark = n_fetch;
    run_pass(1, cyc);
    chk("R9 buffer count", n_fetch - mark, 7);
    for (int i = 0; i < 7; i++) begin
      chk($sformatf("R3 ptr %0d", i), lg_ptr[mark + i], VEC[i][64:33]);
      chk($sformatf("R8 len %0d", i), lg_len[mark + i], VEC[i][32:17]);
      chk($sformatf("R8 oversize %0d", i), lg_ov[mark + i], VEC[i][16]);
      chk($sformatf("R9 frame_done %0d", i), lg_fd[mark + i], VEC[i][81]);
      if (VEC[i][81]) chk($sformatf("R9 frame_bytes %0d", i), lg_fb[mark + i], VEC[i][15:0]);
      chk($sformatf("R5 writeback %0d", i), mem[8'h10 + 2 * i],
          w0(0, VEC[i][82], VEC[i][81], VEC[i][80:65]));
    end
    chk("R6 wrap then R4 stop", cur_ptr, 32'h40);

    // Unaligned ring start, empty ring.
    set_ring(32'h83);
    chk("R7 low bits dropped", cur_ptr, 32'h80);
    mark = n_fetch;
    run_pass(1, cyc);
    chk("R4 empty pass length", cyc, 3);
    chk("R4 no fetch", n_fetch - mark, 0);
    chk("R4 ptr held", cur_ptr, 32'h80);

    // Kicks during a pass.
    run_pass(2, cyc);
    chk("R10 one extra pass", cyc, 6);
    run_pass(3, cyc);
    chk("R10 only one extra", cyc, 6);

    // Resume from the stop point.
    mem_put(32'h80, w0(1, 0, 1, 16'd40));
    mem_put(32'h84, 32'h2000_0000);
    mark = n_fetch;
    run_pass(1, cyc);
    chk("R4 resume fetch count", n_fetch - mark, 1);
    chk("R3 resume ptr", lg_ptr[mark], 32'h2000_0000);
    chk("R9 resume frame_bytes", lg_fb[mark], 16'd40);
    chk("R6 step by 8", cur_ptr, 32'h88);
    chk("R11 pass length", cyc, 6);

    finish_up();
  end
endmodule